// File: doc/BRIEF.md
# Programmable Noise Generator Core

This block produces the pseudo-random on/off waveform of a noise sound channel. A down-counting frequency timer, whose reload value is picked from a small nonlinear table of base divisors and scaled by a power-of-two shift, issues a single tick each time it expires. Each tick advances a right-shifting Galois shift register. The bit shifted out on that tick becomes the channel's output level.

The register runs in a long (15-bit) or a short (7-bit) mode. The two modes differ only in their seed value and in the feedback mask. When the level is high and the channel is active, the block presents the externally supplied volume as a 4-bit sample; otherwise the sample is zero. A trigger pulse restarts the waveform from a known state. Register decoding, envelope, mixing and analog conversion happen elsewhere.

Top module: `noise_gen`

## Requirements
- R1: During and right after reset, `level` is low and `sample` is zero.
- R2: The tick period, counted in enabled cycles, is 4 × base × 2^`rate_shift`. The base follows `rate_code`: 0→8, 1→16, 2→32, 3→48, 4→64, 5→80, 6→96, 7→112. The first tick after a trigger falls on the period-th enabled cycle, and each later tick follows one period after the one before.
- R3: On a tick, bit 0 of the register is the carry and the register shifts right by one. When the carry is 1, the shifted word is XORed with 0x6000 if `short_mode` is 0, or with 0x0060 if `short_mode` is 1.
- R4: `level` holds the carry of the latest tick. `sample` equals `volume` when `level` is high and `active` is high, and zero otherwise.
- R5: A trigger seeds the register with 0x4000 (long mode) or 0x0040 (short mode), forces `level` low and reloads the timer with the full period. It takes precedence over a tick in the same cycle.
- R6: Neither the timer nor the register advances in a cycle in which `active` or `tick_en` is low. While `active` is low, `sample` is zero.
- R7: A period above 65535 (16-bit timer) holds both the timer and the register until the period fits again.
- R8: Changes of `rate_code` and `rate_shift` take effect at the next timer reload, not during a countdown already in progress. The feedback mask follows the current `short_mode` on every tick.
- R9: From its seed, the short mode repeats its level pattern every 127 ticks. The register never reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | System-cycle enable; the timer counts only when high |
| active | input | 1 | Channel running flag |
| trigger | input | 1 | One-cycle restart pulse |
| rate_code | input | 3 | Base divisor selector |
| rate_shift | input | 4 | Power-of-two period scale |
| short_mode | input | 1 | 1 selects the 7-bit sequence, 0 the 15-bit one |
| volume | input | 4 | Current channel volume |
| level | output | 1 | Carry of the most recent tick |
| sample | output | 4 | Volume when high and active, else zero |

## Verification
The assertions assume that `trigger` is applied before the channel is expected to run. They also assume that a trigger is not issued while the period is out of range, because the timer would then be loaded with a truncated value. The stimulus triggers every run in a valid configuration and enters the out-of-range shift only in the middle of a countdown. The bench models the timer and register per cycle and compares `level` and `sample` on every cycle. It also checks the first rising edge of `level` against arithmetic expectations: 7 periods from the short seed and 15 from the long seed, adjusted for held, inactive and disabled cycles.

// File: rtl/noise_gen_pkg.sv
// Shared helpers for the noise generator.
// Assumes a 3-bit rate code; base × 4 fits in 9 bits.
package noise_gen_pkg;

    localparam int CODE_W  = 3;
    localparam int BASE4_W = 9;

    // Base divisor multiplied by four: code 0 gives 32, code n gives 64 × n.
    function automatic logic [BASE4_W-1:0] base_x4(input logic [CODE_W-1:0] code);
        logic [BASE4_W-1:0] r;
        if (code == '0) r = BASE4_W'(32);
        else            r = {code, 6'b000000};
        return r;
    endfunction

endpackage

// File: rtl/noise_timer.sv
// Frequency timer: computes the period from code and shift and counts it down.
// Issues a one-cycle tick on expiry, then reloads with the period in force at that time.
// Assumes a trigger is given in a valid configuration; holds while the period is too wide.
module noise_timer #(
    parameter int TMR_W   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick_en,
    input  logic                           active,
    input  logic                           trigger,
    input  logic [noise_gen_pkg::CODE_W-1:0] rate_code,
    input  logic [SHIFT_W-1:0]             rate_shift,
    output logic                           tick
);
    localparam int MAX_SH = (1 << SHIFT_W) - 1;
    localparam int PER_W  = noise_gen_pkg::BASE4_W + MAX_SH;

    logic [PER_W-1:0] per_wide;
    logic [TMR_W-1:0] period;
    logic [TMR_W-1:0] cnt;
    logic             hold;
    logic             step;
    logic             expire;

    // Period from the table scaled by the shift; flag values beyond the timer width.
    always_comb begin
        per_wide = PER_W'(noise_gen_pkg::base_x4(rate_code)) << rate_shift;
        period   = per_wide[TMR_W-1:0];
        hold     = |per_wide[PER_W-1:TMR_W];
        step     = tick_en && active && !hold;
        expire   = (cnt <= TMR_W'(1));
        tick     = step && expire && !trigger;
    end

    // Countdown: trigger reloads, expiry reloads, otherwise decrement on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (trigger) cnt <= period;
        else if (step) begin
            if (expire) cnt <= period;
            else        cnt <= cnt - TMR_W'(1);
        end
    end

    logic [TMR_W-1:0] period_d;
    // Previous period kept for the reload check.
    always_ff @(posedge clk) begin
        if (!rst_n) period_d <= '0;
        else        period_d <= period;
    end

    AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick) |-> cnt == period_d) else $error("reload"); // R2
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !trigger) |=> $stable(cnt)) else $error("hold"); // R7

endmodule

// File: rtl/noise_lfsr.sv
// Galois shift register with a selectable long or short feedback mask.
// The carry shifted out on each tick becomes the output level.
// Assumes tick and trigger come from the timer and the control logic, one cycle wide.
module noise_lfsr #(
    parameter int LONG_W  = 15,
    parameter int SHORT_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trigger,
    input  logic short_mode,
    output logic level
);
    localparam logic [LONG_W-1:0] LONG_SEED  = LONG_W'(1) << (LONG_W - 1);
    localparam logic [LONG_W-1:0] SHORT_SEED = LONG_W'(1) << (SHORT_W - 1);
    localparam logic [LONG_W-1:0] LONG_MASK  = LONG_W'(3) << (LONG_W - 2);
    localparam logic [LONG_W-1:0] SHORT_MASK = LONG_W'(3) << (SHORT_W - 2);

    logic [LONG_W-1:0] state_q;
    logic [LONG_W-1:0] state_nx;
    logic              level_q;

    // Next word: shift right and fold in the mode mask when the carry is set.
    always_comb begin
        state_nx = state_q >> 1;
        if (state_q[0]) state_nx = state_nx ^ (short_mode ? SHORT_MASK : LONG_MASK);
    end

    // Register update: seed on trigger, advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LONG_SEED;
            level_q <= 1'b0;
        end else if (trigger) begin
            state_q <= short_mode ? SHORT_SEED : LONG_SEED;
            level_q <= 1'b0;
        end else if (tick) begin
            state_q <= state_nx;
            level_q <= state_q[0];
        end
    end

    assign level = level_q;

    AST_TRIG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> !level_q) else $error("trig"); // R5
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0) else $error("zero"); // R9
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !trigger) |=> $stable(state_q) && $stable(level_q)) else $error("idle"); // R6

endmodule

// File: rtl/noise_gen.sv
// Noise generator top: timer, shift register and sample gating.
// Assumes volume is supplied from outside and already valid.
module noise_gen #(
    parameter int TMR_W   = 16,
    parameter int SHIFT_W = 4,
    parameter int LONG_W  = 15,
    parameter int SHORT_W = 7,
    parameter int VOL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               active,
    input  logic               trigger,
    input  logic [2:0]         rate_code,
    input  logic [SHIFT_W-1:0] rate_shift,
    input  logic               short_mode,
    input  logic [VOL_W-1:0]   volume,
    output logic               level,
    output logic [VOL_W-1:0]   sample
);
    logic tick;

    noise_timer #(.TMR_W(TMR_W), .SHIFT_W(SHIFT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .active(active),
        .trigger(trigger), .rate_code(rate_code), .rate_shift(rate_shift),
        .tick(tick)
    );

    noise_lfsr #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger),
        .short_mode(short_mode), .level(level)
    );

    // Sample gating: volume only while running and high.
    always_comb sample = (active && level) ? volume : '0;

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (active && tick_en)) else $error("gate"); // R6

endmodule

// File: tb/noise_gen_bench.sv
`timescale 1ns/1ps
module noise_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       active = 1'b1;
    logic       trigger = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic [3:0] rate_shift = 4'd0;
    logic       short_mode = 1'b1;
    logic [3:0] volume = 4'hA;
    logic       level;
    logic [3:0] sample;

    always #5 clk = ~clk;

    noise_gen u_noise_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .active(active),
        .trigger(trigger), .rate_code(rate_code), .rate_shift(rate_shift),
        .short_mode(short_mode), .volume(volume), .level(level), .sample(sample)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_cnt = 0;
    logic [14:0] m_lfsr = 15'h4000;
    logic m_level = 1'b0;

    function automatic int per_of(input int code, input int sh);
        int b;
        case (code)
            0: b = 8;   1: b = 16;  2: b = 32;  3: b = 48;
            4: b = 64;  5: b = 80;  6: b = 96;  default: b = 112;
        endcase
        return b * 4 * (1 << sh);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: update the model from current inputs, then compare outputs.
    task automatic cyc();
        int p;
        bit c;
        p = per_of(int'(rate_code), int'(rate_shift));
        if (!rst_n) begin
            m_lfsr = 15'h4000; m_level = 0; m_cnt = 0;
        end else if (trigger) begin
            m_cnt = p & 16'hFFFF;
            m_lfsr = short_mode ? 15'h0040 : 15'h4000;
            m_level = 0;
        end else if (tick_en && active && p <= 65535) begin
            if (m_cnt <= 1) begin
                m_cnt = p;
                c = m_lfsr[0];
                m_lfsr = m_lfsr >> 1;
                if (c) m_lfsr = m_lfsr ^ (short_mode ? 15'h0060 : 15'h6000);
                m_level = c;
            end else m_cnt = m_cnt - 1;
        end
        @(posedge clk);
        #1;
        chk(level == m_level, "R3 R4 level", int'(level), int'(m_level));
        chk(sample == ((active && m_level) ? volume : 4'd0), "R4 R6 sample",
            int'(sample), int'((active && m_level) ? volume : 4'd0));
    endtask

    task automatic run(input int n);
        repeat (n) cyc();
    endtask

    task automatic trig();
        trigger = 1'b1; cyc(); trigger = 1'b0;
    endtask

    task automatic wait_rise(input int limit, output int n);
        n = 0;
        while (level == 1'b0 && n < limit) begin cyc(); n++; end
    endtask

    initial begin
        #1900000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic arr [127];
        run(3);
        chk(level == 1'b0, "R1 reset level", int'(level), 0);
        chk(sample == 4'd0, "R1 reset sample", int'(sample), 0);
        rst_n = 1'b1;
        cyc();
        chk(level == 1'b0 && sample == 4'd0, "R1 after reset", int'(sample), 0);

        // R2: short seed rises on tick 7; sweep codes and two shifts
        for (int sh = 0; sh < 2; sh++) begin
            for (int c = 0; c < 8; c++) begin
                rate_code = 3'(c); rate_shift = 4'(sh); short_mode = 1'b1;
                trig();
                wait_rise(7 * per_of(c, sh) + 10, n);
                chk(n == 7 * per_of(c, sh), "R2 period", n, 7 * per_of(c, sh));
            end
        end

        // R3: long seed rises on tick 15
        rate_code = 3'd0; rate_shift = 4'd0; short_mode = 1'b0;
        trig();
        wait_rise(600, n);
        chk(n == 15 * 32, "R3 long mask", n, 480);
        run(32 * 300);

        // R4: sample follows volume while high
        short_mode = 1'b1;
        trig();
        wait_rise(300, n);
        for (int v = 0; v < 16; v++) begin
            volume = 4'(v);
            #1;
            chk(sample == 4'(v), "R4 sample volume", int'(sample), v);
        end
        volume = 4'hA;

        // R5: trigger while high forces low and restarts the count
        trig();
        chk(level == 1'b0, "R5 trigger low", int'(level), 0);
        wait_rise(300, n);
        chk(n == 224, "R5 reseed", n, 224);

        // R6: inactive while high gives zero sample; frozen countdown
        active = 1'b0;
        cyc();
        chk(sample == 4'd0, "R6 inactive sample", int'(sample), 0);
        active = 1'b1;
        trig();
        run(50);
        active = 1'b0; run(500); active = 1'b1;
        wait_rise(400, n);
        chk(n == 174, "R6 inactive hold", n, 174);

        // R6: enable every other cycle doubles the time
        trig();
        n = 0;
        while (level == 1'b0 && n < 1000) begin
            n++; tick_en = (n % 2 == 0); cyc();
        end
        tick_en = 1'b1;
        chk(n == 448, "R6 tick_en gating", n, 448);

        // R7: out-of-range period holds timer and register
        trig();
        run(100);
        rate_shift = 4'd11; run(3000); rate_shift = 4'd0;
        wait_rise(400, n);
        chk(n == 124, "R7 hold", n, 124);

        // R8: new code applies only at the next reload
        trig();
        run(10);
        rate_code = 3'd1;
        wait_rise(600, n);
        chk(n == 406, "R8 reload timing", n, 406);
        rate_code = 3'd0;

        // R9: short pattern repeats every 127 ticks
        trig();
        for (int i = 0; i < 127; i++) begin run(32); arr[i] = level; end
        for (int i = 0; i < 127; i++) begin
            run(32);
            chk(level == arr[i], "R9 repeat", int'(level), int'(arr[i]));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule